// File: doc/BRIEF.md
# Oversampled Bit Synchronizer with Glitch Filter

This block turns a raw demodulated serial stream into clean data plus a recovered bit clock. A sampling tick arrives at 29 times the bit rate. The block takes one sample of the raw input on each tick and passes it through a majority-vote glitch filter. A phase counter, 0 to 28, is steered by the edges of the filtered stream. When the counter reaches its mid-bit value, a one-cycle strobe qualifies the filtered bit for a downstream receive FIFO. The bit rate (0.6 to 115.2 kbps) is set only through the tick spacing, so nothing inside the block depends on the absolute rate.

The phase loop has two gains. Fast tracking snaps the counter to phase 0 on every filtered edge. Slow tracking moves it by at most one step per edge. Slow tracking rejects noise better, but it settles more slowly and needs more accurate incoming bit timing. Automatic mode tracks fast after a restart and changes to slow once lock is declared. Lock requires eight consecutive edges that land close to the expected phase.

The output is a valid-only stream: `out_valid` marks a beat and `out_data` carries it. There is no ready input, because the incoming air stream cannot be paused. The consumer must accept every beat in the cycle it is offered, or lose it.

Top module: `bitsync_recovery`

## Requirements
- R1: After `rst_n` low or a `restart` pulse, `out_data`, `out_valid` and `locked` are 0, the phase counter is at 0 and the filter history holds zeros.
- R2: The filtered value is the majority of the five most recent samples. A pulse of two samples, or samples alternating 1,0,1 against a steady 0, never changes `out_data`. A new level held for three samples appears on `out_data` right after the third such tick.
- R3: `out_data`, `out_valid` and the phase state change only on a clock edge where `samp_tick` is high, apart from reset and restart.
- R4: Fast tracking (`mode` = 2'b00) sets the phase to 0 on the tick that detects a filtered edge. The strobe follows on the 14th tick after that tick, which is tick position 16 of a bit whose first new-level sample is position 0.
- R5: Slow tracking (`mode` = 2'b01) moves the phase by one step toward 0 on each filtered edge, and not at all when the edge already lands at phase 0. The first bit after a restart therefore strobes at position 14, and a bit after a 5-tick late edge strobes at position 12.
- R6: Automatic mode (`mode` = 2'b10 or 2'b11) tracks like fast mode while `locked` is 0 and like slow mode while `locked` is 1.
- R7: `out_valid` is high for exactly one clock, only after a tick, at the tick where the phase counter takes the value 14. Once tracking has settled, `out_data` at each strobe equals the transmitted bit, one strobe per bit.
- R8: An edge is good when the phase it lands on is within 3 counts of 0, taking the wrap at 29 into account. `locked` rises on the 8th consecutive good edge, and any edge outside that window restarts the run.
- R9: Once set, `locked` stays 1 through edges outside the window until `restart` or reset.
- R10: The phase counter runs 0 to 28 and wraps, so with no edges the strobes are exactly 29 ticks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous restart of filter, phase and lock |
| samp_tick | input | 1 | One-cycle sampling tick at 29 times the bit rate |
| raw_in | input | 1 | Raw demodulated data |
| mode | input | 2 | Tracking mode: 00 fast, 01 slow, 10/11 automatic |
| out_data | output | 1 | Filtered data |
| out_valid | output | 1 | One-cycle mid-bit strobe qualifying out_data |
| locked | output | 1 | Lock flag |

## Verification
Each tracking mode is fed a long alternating preamble followed by payloads that mix dense transitions with runs of up to fourteen equal bits. This shows that decoding holds both when edges are frequent and when the counter must free-run between them. One edge delayed by five ticks after lock separates fast, slow and automatic tracking by the tick position of the next strobe (16, 12, 12). The first bit after restart separates them again (16, 14, 16), which shows that automatic mode really starts fast. Two-sample pulses, 1,0,1 patterns and a three-sample step mark the exact threshold of the vote. Bit lengths alternating between 29 and 34 ticks show that a single off-window edge breaks the lock run.

// File: rtl/bitsync_pkg.sv
package bitsync_pkg;
  typedef enum logic [1:0] {
    TRK_FAST     = 2'b00,
    TRK_SLOW     = 2'b01,
    TRK_AUTO     = 2'b10,
    TRK_AUTO_ALT = 2'b11
  } trk_mode_e;
endpackage

// File: rtl/bitsync_vote.sv
module bitsync_vote #(
  parameter int TAPS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic din,
  output logic dout,
  output logic edge_o
);
  localparam int CW = $clog2(TAPS + 1);
  localparam logic [CW-1:0] THR = CW'(TAPS / 2 + 1);

  logic [TAPS-1:0] win_q, win_d;
  logic [CW-1:0]   ones;
  logic            vote;

  always_comb begin
    win_d = {win_q[TAPS-2:0], din};
    ones  = '0;
    for (int i = 0; i < TAPS; i++) ones = ones + CW'(win_d[i]);
    vote  = (ones >= THR);
  end

  // a filtered edge exists when this tick's vote disagrees with the held value
  assign edge_o = tick && (vote != dout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      dout  <= 1'b0;
    end else if (clr) begin
      win_q <= '0;
      dout  <= 1'b0;
    end else if (tick) begin
      win_q <= win_d;
      dout  <= vote;
    end
  end
endmodule

// File: rtl/bitsync_phase.sv
module bitsync_phase #(
  parameter int OSR = 29,
  parameter int WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic edge_i,
  input  logic slow_i,
  output logic strobe_o,
  output logic good_o,
  output logic bad_o
);
  localparam int PW = $clog2(OSR + 1);
  localparam logic [PW-1:0] LAST = PW'(OSR - 1);
  localparam logic [PW-1:0] MID  = PW'(OSR / 2);
  localparam logic [PW-1:0] SPAN = PW'(OSR);
  localparam logic [PW-1:0] WLIM = PW'(WIN);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] ph_q, nxt, ph_d, mag;
  logic          late, early;

  always_comb begin
    nxt   = (ph_q == LAST) ? '0 : ph_q + ONE;
    // counter ahead of the edge (late edge relative to phase 0) or behind it
    late  = (nxt != '0) && (nxt <= MID);
    early = (nxt > MID);
    mag   = early ? (SPAN - nxt) : nxt;
    if (!edge_i)      ph_d = nxt;
    else if (!slow_i) ph_d = '0;
    else if (late)    ph_d = nxt - ONE;
    else if (early)   ph_d = (nxt == LAST) ? '0 : nxt + ONE;
    else              ph_d = nxt;
    good_o = tick && edge_i && (mag <= WLIM);
    bad_o  = tick && edge_i && (mag > WLIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= '0;
      strobe_o <= 1'b0;
    end else if (clr) begin
      ph_q     <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= tick && (ph_d == MID);
      if (tick) ph_q <= ph_d;
    end
  end
endmodule

// File: rtl/bitsync_lock.sv
module bitsync_lock #(
  parameter int RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic good_i,
  input  logic bad_i,
  output logic locked_o
);
  localparam int CW = $clog2(RUN);
  localparam logic [CW-1:0] LASTC = CW'(RUN - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      locked_o <= 1'b0;
    end else if (clr) begin
      run_q    <= '0;
      locked_o <= 1'b0;
    end else if (bad_i) begin
      run_q <= '0;
    end else if (good_i) begin
      if (run_q == LASTC) locked_o <= 1'b1;
      else                run_q    <= run_q + CW'(1);
    end
  end
endmodule

// File: rtl/bitsync_recovery.sv
module bitsync_recovery
  import bitsync_pkg::*;
#(
  parameter int OSR  = 29,
  parameter int TAPS = 5,
  parameter int WIN  = 3,
  parameter int RUN  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       samp_tick,
  input  logic       raw_in,
  input  logic [1:0] mode,
  output logic       out_data,
  output logic       out_valid,
  output logic       locked
);
  trk_mode_e trk;
  logic      filt_edge, slow_sel, good_edge, bad_edge;

  assign trk      = trk_mode_e'(mode);
  assign slow_sel = (trk == TRK_SLOW) ||
                    (((trk == TRK_AUTO) || (trk == TRK_AUTO_ALT)) && locked);

  bitsync_vote #(.TAPS(TAPS)) u_vote (
    .clk(clk), .rst_n(rst_n), .clr(restart), .tick(samp_tick),
    .din(raw_in), .dout(out_data), .edge_o(filt_edge)
  );

  bitsync_phase #(.OSR(OSR), .WIN(WIN)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(restart), .tick(samp_tick),
    .edge_i(filt_edge), .slow_i(slow_sel),
    .strobe_o(out_valid), .good_o(good_edge), .bad_o(bad_edge)
  );

  bitsync_lock #(.RUN(RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .clr(restart),
    .good_i(good_edge), .bad_i(bad_edge), .locked_o(locked)
  );
endmodule

// File: rtl/bitsync_checks.sv
module bitsync_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       restart,
  input logic       samp_tick,
  input logic       raw_in,
  input logic [1:0] mode,
  input logic       out_data,
  input logic       out_valid,
  input logic       locked
);
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_strobe_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(samp_tick) && !$past(restart)));

  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(samp_tick) && !$past(restart)) |-> $stable(out_data));

  assert_restart_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!locked && !out_data && !out_valid));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !restart) |=> locked);
endmodule

bind bitsync_recovery bitsync_checks u_chk (.*);

// File: tb/tb_bitsync_recovery.sv
module tb_bitsync_recovery;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic       samp_tick = 1'b0;
  logic       raw_in = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       out_data, out_valid, locked;

  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;
  logic [15:0] rx;
  int         n_stb, last_pos;
  bit         saw_hi, saw_stb;

  always #2.5 clk = ~clk;

  bitsync_recovery dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .samp_tick(samp_tick),
    .raw_in(raw_in), .mode(mode), .out_data(out_data),
    .out_valid(out_valid), .locked(locked)
  );

  // {mode, payload}
  localparam logic [17:0] VEC [6] = '{
    {2'b00, 16'hA5C3}, {2'b01, 16'hFF00}, {2'b10, 16'h0F0F},
    {2'b11, 16'h1234}, {2'b01, 16'hC0DE}, {2'b00, 16'h8001}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic b, input int pos);
    raw_in    = b;
    samp_tick = 1'b1;
    @(negedge clk);
    samp_tick = 1'b0;
    if (out_valid) begin
      rx       = {rx[14:0], out_data};
      n_stb++;
      last_pos = pos;
    end
    if (out_data) saw_hi = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int len);
    for (int i = 0; i < len; i++) do_tick(b, i);
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    @(negedge clk);
  endtask

  task automatic preamble();
    for (int i = 0; i < 16; i++) send_bit(logic'(~i[0]), 29);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_data && !out_valid && !locked, "R1 reset outputs", {out_data, out_valid, locked}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of decode vectors
    for (int v = 0; v < 6; v++) begin
      mode = VEC[v][17:16];
      do_restart();
      preamble();
      chk(locked == 1'b1, "R8 lock after preamble", locked, 1);
      n_stb = 0;
      rx    = '0;
      for (int b = 15; b >= 0; b--) send_bit(VEC[v][b], 29);
      chk(n_stb == 16, "R7 one strobe per bit", n_stb, 16);
      chk(rx == VEC[v][15:0], "R7 decoded payload", rx, VEC[v][15:0]);
    end

    // first bit after restart: fast 16, slow 14, auto 16
    for (int m = 0; m < 3; m++) begin
      mode = 2'(m);
      do_restart();
      last_pos = -1;
      n_stb    = 0;
      send_bit(1'b1, 29);
      chk(last_pos == ((m == 1) ? 14 : 16), (m == 0) ? "R4 first strobe fast" :
          (m == 1) ? "R5 first strobe slow" : "R6 auto starts fast",
          last_pos, (m == 1) ? 14 : 16);
      chk(n_stb == 1, "R10 single strobe in first bit", n_stb, 1);
    end

    // late edge after lock: fast 16, slow 12, auto 12
    for (int m = 0; m < 3; m++) begin
      mode = 2'(m);
      do_restart();
      preamble();
      send_bit(1'b1, 34);
      last_pos = -1;
      send_bit(1'b0, 29);
      chk(last_pos == ((m == 0) ? 16 : 12), (m == 0) ? "R4 late edge fast" :
          (m == 1) ? "R5 late edge slow" : "R6 auto slow after lock",
          last_pos, (m == 0) ? 16 : 12);
      chk(locked == 1'b1, "R9 lock held after off-window edge", locked, 1);
      do_restart();
      chk(!locked && !out_data && !out_valid, "R1 restart clears", {out_data, out_valid, locked}, 0);
    end

    // free run with no edges: strobes 29 ticks apart
    mode = 2'b00;
    do_restart();
    send_bit(1'b1, 29);
    n_stb = 0;
    last_pos = -1;
    send_bit(1'b1, 58);
    chk(n_stb == 2 && last_pos == 45, "R10 wrap period 29", last_pos, 45);

    // lock on exactly the 8th good edge
    do_restart();
    for (int b = 0; b < 7; b++) send_bit(logic'(~b[0]), 29);
    chk(locked == 1'b0, "R8 no lock after 7 edges", locked, 0);
    send_bit(1'b0, 29);
    chk(locked == 1'b1, "R8 lock on 8th edge", locked, 1);

    // off-window edges break the run
    do_restart();
    for (int b = 0; b < 20; b++) send_bit(logic'(~b[0]), b[0] ? 34 : 29);
    chk(locked == 1'b0, "R8 run reset by 5-tick error", locked, 0);

    // glitch filter
    do_restart();
    send_bit(1'b0, 40);
    saw_hi = 1'b0;
    send_bit(1'b1, 2);
    send_bit(1'b0, 20);
    do_tick(1'b1, 0); do_tick(1'b0, 1); do_tick(1'b1, 2);
    send_bit(1'b0, 20);
    chk(saw_hi == 1'b0, "R2 short pulses rejected", saw_hi, 0);
    do_tick(1'b1, 0);
    chk(out_data == 1'b0, "R2 one sample", out_data, 0);
    do_tick(1'b1, 1);
    chk(out_data == 1'b0, "R2 two samples", out_data, 0);
    do_tick(1'b1, 2);
    chk(out_data == 1'b1, "R2 three samples pass", out_data, 1);

    // input changes without ticks have no effect
    raw_in  = 1'b0;
    saw_stb = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_valid) saw_stb = 1'b1;
    end
    chk(out_data == 1'b1 && !saw_stb, "R3 no change without ticks", out_data, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule